// File: doc/BRIEF.md
# PLL Register Front End with Settling Timer

This block is the software-visible register file of a phase-locked loop. It keeps four 32-bit words: a control/status word, a power word, a feedback-divider word and a post-divider word. A small synchronous bus reaches them, with one write strobe, one read strobe and a 2-bit word address. The block also models loop settling, since no analog loop is present. A free-running cycle counter and an armed deadline decide when the lock flag shows. The deadline is set when the loop becomes powered and configured, and again whenever the reference or feedback divider changes.

The decoded divider fields and a powered-and-configured status are driven on dedicated outputs for the clock-generation logic nearby. A reference or post-divider field of zero is presented as one. Reads take one cycle. The lock flag is merged into bit 31 of the control/status read value, and that bit is never stored.

Top module: `pll_lock_regs`

## Requirements
- R1: After reset the words read 0x00000001 (address 0), 0x0000002D (address 1), 0x00000000 (address 2) and 0x00077000 (address 3), and `locked_o` and `run_ok_o` are 0.
- R2: A read strobed with `rd_en` on a clock edge returns the word selected by `addr` on `rdata` with `rvalid` high after that edge, for one cycle. Address 0 is control/status, 1 is power, 2 is feedback, 3 is post-divider.
- R3: The reference divider is bits 5:0 of word 0 and the feedback divider is bits 11:0 of word 2. Post-divider A is bits 18:16 and post-divider B is bits 14:12 of word 3. `ref_div_o`, `post_a_o` and `post_b_o` show 1 when their field is 0. `fb_div_o` shows the raw field.
- R4: `run_ok_o` is 1 exactly when the feedback field is nonzero and both bit 0 (main power-down) and bit 5 (oscillator power-down) of word 1 are 0. Bit 8 of word 0 (bypass) has no effect on it.
- R5: Bit 31 of a word-0 read is the lock flag. A write to bit 31 is discarded, and all other bits of every word read back as written.
- R6: A write that leaves the loop powered and configured while no deadline is armed arms one at the current count plus LOCK_DELAY (2000). `locked_o` then rises on the 1999th clock edge after the write edge.
- R7: A write that changes the reference or feedback field while the loop stays powered and configured re-arms the deadline. The lock flag drops after the write edge and returns LOCK_DELAY-1 edges later.
- R8: Writes to word 3, and writes that leave both divider fields unchanged, keep the existing deadline. An established lock stays 1 and a pending one keeps its original timing.
- R9: A write that leaves the loop not powered and configured disarms the deadline. The lock flag is 0 from the next cycle, and a later re-power waits a full LOCK_DELAY-1 edges.
- R10: With no writes, an established lock flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid |
| ref_div_o | output | 6 | Effective reference divider |
| fb_div_o | output | 12 | Feedback divider field |
| post_a_o | output | 3 | Effective post-divider A |
| post_b_o | output | 3 | Effective post-divider B |
| run_ok_o | output | 1 | Powered and configured |
| locked_o | output | 1 | Lock flag |

## Verification
The hardest case to reach is a settling window interrupted partway through. An unrelated write lands while a deadline is pending, and that write must neither restart the window nor cut it short. The stimulus changes the reference divider and lets 1000 cycles pass. It then writes the post-divider word. It checks that the lock still appears at the edge set by the earlier divider write. Further sequences repeat an unchanged feedback value while locked, power down with a pending lock, and power back up, and each edge count is checked at the exact cycle.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;

  localparam int WORD_W = 32;
  localparam int NWORDS = 4;
  localparam int REF_W  = 6;
  localparam int FB_W   = 12;
  localparam int PST_W  = 3;

  localparam int unsigned A_CS   = 0;
  localparam int unsigned A_PWR  = 1;
  localparam int unsigned A_FB   = 2;
  localparam int unsigned A_POST = 3;

  localparam int LOCK_BIT = 31;
  localparam int PD_BIT   = 0;
  localparam int VPD_BIT  = 5;

  typedef logic [NWORDS-1:0][WORD_W-1:0] bank_t;

  function automatic logic [WORD_W-1:0] reset_word(input int unsigned idx);
    case (idx)
      A_CS:    return 32'h0000_0001;
      A_PWR:   return 32'h0000_002D;
      A_FB:    return 32'h0000_0000;
      default: return 32'h0007_7000;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] write_mask(input int unsigned idx);
    if (idx == A_CS) return ~(32'h1 << LOCK_BIT);
    return '1;
  endfunction

  function automatic logic [REF_W-1:0] ref_field(input logic [WORD_W-1:0] w);
    return w[REF_W-1:0];
  endfunction

  function automatic logic [FB_W-1:0] fb_field(input logic [WORD_W-1:0] w);
    return w[FB_W-1:0];
  endfunction

  function automatic logic [PST_W-1:0] post_a_field(input logic [WORD_W-1:0] w);
    return w[18:16];
  endfunction

  function automatic logic [PST_W-1:0] post_b_field(input logic [WORD_W-1:0] w);
    return w[14:12];
  endfunction

  function automatic logic [REF_W-1:0] eff_ref(input logic [REF_W-1:0] v);
    return (v == '0) ? REF_W'(1) : v;
  endfunction

  function automatic logic [PST_W-1:0] eff_post(input logic [PST_W-1:0] v);
    return (v == '0) ? PST_W'(1) : v;
  endfunction

  function automatic logic loop_ready(input logic [WORD_W-1:0] pwr,
                                      input logic [WORD_W-1:0] fb);
    return (fb_field(fb) != '0) && !pwr[PD_BIT] && !pwr[VPD_BIT];
  endfunction

endpackage

// File: rtl/pll_reg_bank.sv
module pll_reg_bank
  import pll_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output bank_t             bank_q,
  output bank_t             bank_nxt,
  output logic              ref_chg,
  output logic              fb_chg
);

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    localparam logic [WORD_W-1:0] RST  = reset_word(gi);
    localparam logic [WORD_W-1:0] MASK = write_mask(gi);
    logic hit;
    assign hit = wr_en && (addr == 2'(gi));

    always_comb begin
      bank_nxt[gi] = bank_q[gi];
      if (hit) bank_nxt[gi] = wdata & MASK;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) bank_q[gi] <= RST;
      else        bank_q[gi] <= bank_nxt[gi];
    end
  end

  assign ref_chg = ref_field(bank_nxt[A_CS]) != ref_field(bank_q[A_CS]);
  assign fb_chg  = fb_field(bank_nxt[A_FB])  != fb_field(bank_q[A_FB]);

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int CNT_W      = 48,
  parameter int LOCK_DELAY = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic ready_now,
  input  logic ready_nxt,
  input  logic div_chg,
  output logic armed_o,
  output logic arm_evt,
  output logic locked_o
);

  localparam logic [CNT_W-1:0] DLY = CNT_W'(LOCK_DELAY);

  logic [CNT_W-1:0] now_q;
  logic [CNT_W-1:0] due_q;
  logic             armed_q;
  logic             disarm_evt;

  always_comb begin
    arm_evt    = 1'b0;
    disarm_evt = 1'b0;
    if (wr_en) begin
      if (!ready_nxt)              disarm_evt = 1'b1;
      else if (!armed_q || div_chg) arm_evt   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q   <= '0;
      due_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      now_q <= now_q + 1'b1;
      if (disarm_evt) begin
        armed_q <= 1'b0;
      end else if (arm_evt) begin
        armed_q <= 1'b1;
        due_q   <= now_q + DLY;
      end
    end
  end

  assign armed_o  = armed_q;
  assign locked_o = ready_now && armed_q && (now_q >= due_q);

endmodule

// File: rtl/pll_read_port.sv
module pll_read_port
  import pll_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  bank_t             bank_q,
  input  logic              lock_flag,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);

  logic [WORD_W-1:0] sel;

  always_comb begin
    sel = bank_q[addr];
    if (addr == 2'(A_CS)) sel[LOCK_BIT] = lock_flag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= sel;
    end
  end

endmodule

// File: rtl/pll_lock_regs.sv
module pll_lock_regs
  import pll_ctl_pkg::*;
#(
  parameter int CNT_W      = 48,
  parameter int LOCK_DELAY = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rvalid,
  output logic [5:0]  ref_div_o,
  output logic [11:0] fb_div_o,
  output logic [2:0]  post_a_o,
  output logic [2:0]  post_b_o,
  output logic        run_ok_o,
  output logic        locked_o
);

  bank_t bank_q;
  bank_t bank_nxt;
  logic  ref_chg;
  logic  fb_chg;
  logic  ready_now;
  logic  ready_nxt;
  logic  armed;
  logic  arm_evt;
  logic  lock_flag;

  pll_reg_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .bank_q   (bank_q),
    .bank_nxt (bank_nxt),
    .ref_chg  (ref_chg),
    .fb_chg   (fb_chg)
  );

  assign ready_now = loop_ready(bank_q[A_PWR],   bank_q[A_FB]);
  assign ready_nxt = loop_ready(bank_nxt[A_PWR], bank_nxt[A_FB]);

  pll_lock_timer #(
    .CNT_W      (CNT_W),
    .LOCK_DELAY (LOCK_DELAY)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .ready_now (ready_now),
    .ready_nxt (ready_nxt),
    .div_chg   (ref_chg || fb_chg),
    .armed_o   (armed),
    .arm_evt   (arm_evt),
    .locked_o  (lock_flag)
  );

  pll_read_port u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .addr      (addr),
    .bank_q    (bank_q),
    .lock_flag (lock_flag),
    .rdata     (rdata),
    .rvalid    (rvalid)
  );

  assign ref_div_o = eff_ref(ref_field(bank_q[A_CS]));
  assign fb_div_o  = fb_field(bank_q[A_FB]);
  assign post_a_o  = eff_post(post_a_field(bank_q[A_POST]));
  assign post_b_o  = eff_post(post_b_field(bank_q[A_POST]));
  assign run_ok_o  = ready_now;
  assign locked_o  = lock_flag;

endmodule

// File: rtl/pll_lock_regs_chk.sv
module pll_lock_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [1:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        rvalid,
  input logic [11:0] fb_div_o,
  input logic        run_ok_o,
  input logic        locked_o,
  input logic        armed,
  input logic        arm_evt
);

  AST_LOCK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> (run_ok_o && armed)); // R9

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid); // R2

  AST_CS_LOCK_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0) |=> (rdata[31] == $past(locked_o))); // R5

  AST_POST_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && locked_o) |=> locked_o); // R8

  AST_FB_CHANGE_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && wdata[11:0] != fb_div_o && wdata[11:0] != 12'd0 && run_ok_o)
      |=> !locked_o); // R7

  AST_FB_CHANGE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && wdata[11:0] != fb_div_o && wdata[11:0] != 12'd0 && run_ok_o)
      |-> arm_evt); // R7

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && locked_o) |=> locked_o); // R10

endmodule

bind pll_lock_regs pll_lock_regs_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .rvalid   (rvalid),
  .fb_div_o (fb_div_o),
  .run_ok_o (run_ok_o),
  .locked_o (locked_o),
  .armed    (armed),
  .arm_evt  (arm_evt)
);

// File: tb/pll_lock_regs_bench.sv
module pll_lock_regs_bench;

  localparam int DLY = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [5:0]  ref_div_o;
  logic [11:0] fb_div_o;
  logic [2:0]  post_a_o;
  logic [2:0]  post_b_o;
  logic        run_ok_o;
  logic        locked_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  pll_lock_regs u_pll_lock_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .ref_div_o(ref_div_o),
    .fb_div_o(fb_div_o), .post_a_o(post_a_o), .post_b_o(post_b_o),
    .run_ok_o(run_ok_o), .locked_o(locked_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 actual=unexpected rvalid expected=no read");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, rdata, e.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // after a write returns, lock must be low for DLY-2 more cycles, then high
  task automatic expect_lock_after(input int already, input string tag);
    idle(DLY - 2 - already);
    check({tag, " lock still low"}, {31'd0, locked_o}, 32'd0);
    idle(1);
    check({tag, " lock rises"}, {31'd0, locked_o}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 locked", {31'd0, locked_o}, 32'd0);
    check("R1 run_ok", {31'd0, run_ok_o}, 32'd0);
    rd(2'd0, 32'h0000_0001, "R1 word0");
    rd(2'd1, 32'h0000_002D, "R1 word1");
    rd(2'd2, 32'h0000_0000, "R1 word2");
    rd(2'd3, 32'h0007_7000, "R1 word3");

    // R3 decoded fields at reset
    check("R3 ref", {26'd0, ref_div_o}, 32'd1);
    check("R3 post_a", {29'd0, post_a_o}, 32'd7);
    check("R3 post_b", {29'd0, post_b_o}, 32'd7);
    wr(2'd3, 32'h0000_0000);
    check("R3 post_a zero->1", {29'd0, post_a_o}, 32'd1);
    check("R3 post_b zero->1", {29'd0, post_b_o}, 32'd1);
    wr(2'd3, 32'h0005_3000);
    check("R3 post_a", {29'd0, post_a_o}, 32'd5);
    check("R3 post_b", {29'd0, post_b_o}, 32'd3);
    wr(2'd0, 32'h0000_0000);
    check("R3 ref zero->1", {26'd0, ref_div_o}, 32'd1);
    wr(2'd0, 32'h0000_0001);

    // R4 powered-and-configured decode
    wr(2'd2, 32'd100);
    check("R3 fb", {20'd0, fb_div_o}, 32'd100);
    check("R4 both pd set", {31'd0, run_ok_o}, 32'd0);
    wr(2'd1, 32'h0000_0020);
    check("R4 vco pd", {31'd0, run_ok_o}, 32'd0);
    wr(2'd1, 32'h0000_0001);
    check("R4 main pd", {31'd0, run_ok_o}, 32'd0);

    // R6 arming from unarmed
    wr(2'd1, 32'h0000_0000);
    check("R4 ready", {31'd0, run_ok_o}, 32'd1);
    expect_lock_after(0, "R6");
    rd(2'd0, 32'h8000_0001, "R5 lock merged");

    // R4/R5 bypass bit and bit31 write ignored, lock kept (R8 same divider)
    wr(2'd0, 32'h8000_0101);
    check("R4 bypass no effect", {31'd0, run_ok_o}, 32'd1);
    check("R8 same ref keeps lock", {31'd0, locked_o}, 32'd1);
    rd(2'd0, 32'h8000_0101, "R5 read locked");

    // R8 post-divider write keeps lock
    wr(2'd3, 32'h0002_2000);
    check("R8 post write keeps lock", {31'd0, locked_o}, 32'd1);
    rd(2'd3, 32'h0002_2000, "R2 word3");

    // R10 hold
    idle(500);
    check("R10 hold", {31'd0, locked_o}, 32'd1);

    // R7 feedback change re-arms
    wr(2'd2, 32'd125);
    check("R7 fb change drops lock", {31'd0, locked_o}, 32'd0);
    expect_lock_after(0, "R7 fb");
    wr(2'd2, 32'd125);
    check("R8 same fb keeps lock", {31'd0, locked_o}, 32'd1);

    // R7 reference change, R8 post write mid-window keeps timing
    wr(2'd0, 32'h0000_0105);
    check("R7 ref change drops lock", {31'd0, locked_o}, 32'd0);
    rd(2'd0, 32'h0000_0105, "R5 bit31 not stored");
    idle(998);
    wr(2'd3, 32'h0003_1000);
    expect_lock_after(1001, "R8 pending kept");
    rd(2'd1, 32'h0000_0000, "R2 word1");

    // R9 power down disarms, re-power waits full delay
    wr(2'd1, 32'h0000_0001);
    check("R9 pd drops lock", {31'd0, locked_o}, 32'd0);
    idle(10);
    wr(2'd1, 32'h0000_0000);
    check("R9 repower not locked", {31'd0, locked_o}, 32'd0);
    expect_lock_after(0, "R9 repower");

    // R9 feedback zero disarms
    wr(2'd2, 32'd0);
    check("R9 fb zero run_ok", {31'd0, run_ok_o}, 32'd0);
    check("R9 fb zero lock", {31'd0, locked_o}, 32'd0);
    rd(2'd0, 32'h0000_0105, "R9 read unlocked");

    idle(3);
    check("R2 scoreboard drained", sb_q.size(), 32'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule